// File: doc/BRIEF.md
# Strobe-Clocked Serial Register Slave

This block gives a host access to a small board-control register file over four wires: an active-low clear line, a strobe clock, a data line from the host and a data line back to the host. All four wires are oversampled by the local system clock through two-flop synchronizers. The strobe's rising edges are found in the system clock domain, and the design has no second clock domain.

A transaction starts when the host pulses the clear line low. The host then clocks in an 8-bit header and a 16-bit data phase, most significant bit first. The top header bit selects a read (1) or a write (0), and the remaining seven bits carry the register address. On a write, the host drives the 16 data bits. On a read, the block drives the addressed register's contents back, one bit per strobe rising edge.

The register file holds a fixed identity word, a fixed firmware version word, a bank of function-enable words, a bank of per-pin enable words and a bank of per-pin direction words. The three writable banks are exported as flat parallel buses for a header pin controller.

Top module: `strobe_reg_slave`

## Requirements
- R1: While the synchronized clear line is low, any partial frame is abandoned and no register changes. The next strobe rising edge after clear returns high is taken as header bit 7.
- R2: A header is 8 bits sent most significant bit first. Bit 7 is the read flag (1 = read, 0 = write) and bits 6:0 are the register address.
- R3: A host bit is captured on the strobe rising edge. Changes on the host data line while the strobe stays high have no effect.
- R4: Write data is 16 bits sent most significant bit first. The register takes the value on the 16th data-phase strobe rising edge.
- R5: On a read, each data-phase strobe rising edge drives the next register bit on `sdo_o`, bit 15 first. The bit holds until the next rising edge.
- R6: Address 0x10 reads as {PLAT_HI, 8'h01}, which is 0x0001 with default parameters.
- R7: Address 0x11 reads as {build[15:12], major[11:8], minor[7:4], patch[3:0]}, with the major field fixed at 0. With default parameters this is 0x2051.
- R8: Writes to 0x10 and 0x11 are discarded.
- R9: Writes to unmapped addresses are discarded, and reads of unmapped addresses return 0x0000. The mapped addresses are 0x10, 0x11, 0x20..0x21, 0x30..0x32 and 0x40..0x42.
- R10: Strobe edges after a frame's 16th data bit change neither registers nor `sdo_o` until the next clear.
- R11: A synchronous reset clears every writable register to 0x0000 and drives `sdo_o` low.
- R12: Word k of the function, pin-enable and direction banks (addresses 0x20+k, 0x30+k and 0x40+k) appears at bits [16k+15:16k] of `func_en_o`, `pin_en_o` and `pin_dir_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial wires |
| rst | input | 1 | Synchronous reset, active high |
| clr_n_i | input | 1 | Frame clear, active low |
| stb_i | input | 1 | Serial strobe clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial read data to the host |
| func_en_o | output | 16*FUNC_WORDS | Function-enable bank |
| pin_en_o | output | 16*PIN_WORDS | Pin-enable bank |
| pin_dir_o | output | 16*PIN_WORDS | Pin-direction bank |

## Verification
The hardest case to reach from the ports is a clear that lands partway through a frame, since only a well-formed frame changes anything visible. The bench abandons frames at chosen points: after five header bits, and after ten data bits of a write. It then checks that the partly shifted state neither leaks into a register nor shifts the bit alignment of the next full frame. It also sends strobe bursts after a completed frame and toggles the data line while the strobe is high, checking that the banks and `sdo_o` stay put. Directed cases are mixed with seeded random reads and writes over mapped and unmapped addresses.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 7;
  localparam int HDR_W  = ADDR_W + 1;

  localparam logic [ADDR_W-1:0] ID_ADDR   = 7'h10;
  localparam logic [ADDR_W-1:0] VER_ADDR  = 7'h11;
  localparam int                FUNC_BASE = 'h20;
  localparam int                PIN_BASE  = 'h30;
  localparam int                DIR_BASE  = 'h40;

  typedef enum logic [1:0] {
    FR_HDR  = 2'd0,
    FR_DATA = 2'd1,
    FR_DONE = 2'd2
  } fr_state_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int             W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;
endmodule

// File: rtl/srs_frame.sv
module srs_frame
  import srs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_s,
  input  logic              stb_s,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] look_addr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              sdo
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  fr_state_t         state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [HDR_W-2:0]  hdr_q;
  logic [DATA_W-1:0] sh_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;
  logic              sdo_q;
  logic              stb_d;
  logic              rise;

  assign rise      = stb_s & ~stb_d;
  assign look_addr = {hdr_q[ADDR_W-2:0], sdi_s};
  assign wr_addr   = addr_q;
  assign wr_data   = {sh_q[DATA_W-2:0], sdi_s};
  assign wr_en     = rise && clr_s && (state_q == FR_DATA) && !rd_q && (cnt_q == DATA_LAST);
  assign sdo       = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= FR_HDR;
      cnt_q   <= '0;
      hdr_q   <= '0;
      sh_q    <= '0;
      addr_q  <= '0;
      rd_q    <= 1'b0;
      sdo_q   <= 1'b0;
      stb_d   <= 1'b0;
    end else begin
      stb_d <= stb_s;
      if (!clr_s) begin
        state_q <= FR_HDR;
        cnt_q   <= '0;
        sdo_q   <= 1'b0;
      end else if (rise) begin
        case (state_q)
          FR_HDR: begin
            hdr_q <= {hdr_q[HDR_W-3:0], sdi_s};
            if (cnt_q == HDR_LAST) begin
              state_q <= FR_DATA;
              cnt_q   <= '0;
              rd_q    <= hdr_q[HDR_W-2];
              addr_q  <= look_addr;
              if (hdr_q[HDR_W-2]) sh_q <= rd_data;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          FR_DATA: begin
            sh_q <= {sh_q[DATA_W-2:0], sdi_s};
            if (rd_q) sdo_q <= sh_q[DATA_W-1];
            if (cnt_q == DATA_LAST) state_q <= FR_DONE;
            else                    cnt_q   <= cnt_q + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // R1: clear forces the framer back to the first header bit
  a_r1_clear_restart: assert property (@(posedge clk) disable iff (rst)
    !clr_s |=> (state_q == FR_HDR && cnt_q == '0));

  // R3: without a strobe rising edge the framer does not advance
  a_r3_hold_without_edge: assert property (@(posedge clk) disable iff (rst)
    (!rise && clr_s) |=> ($stable(cnt_q) && $stable(state_q)));

  // R10: a finished frame keeps the return line still until clear
  a_r10_done_quiet: assert property (@(posedge clk) disable iff (rst)
    (state_q == FR_DONE && clr_s) |=> $stable(sdo_q));

  // R11: reset leaves the return line low
  a_r11_reset_sdo: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !sdo_q);
endmodule

// File: rtl/srs_regfile.sv
module srs_regfile
  import srs_pkg::*;
#(
  parameter int         FUNC_WORDS = 2,
  parameter int         PIN_WORDS  = 3,
  parameter logic [7:0] PLAT_HI    = 8'h00,
  parameter logic [3:0] FW_BUILD   = 4'h2,
  parameter logic [3:0] FW_MINOR   = 4'h5,
  parameter logic [3:0] FW_PATCH   = 4'h1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [DATA_W-1:0]            rd_data,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [DATA_W-1:0]            wr_data,
  output logic [FUNC_WORDS*DATA_W-1:0] func_bus,
  output logic [PIN_WORDS*DATA_W-1:0]  en_bus,
  output logic [PIN_WORDS*DATA_W-1:0]  dir_bus
);
  localparam logic [DATA_W-1:0] ID_WORD  = {PLAT_HI, 8'h01};
  localparam logic [DATA_W-1:0] VER_WORD = {FW_BUILD, 4'h0, FW_MINOR, FW_PATCH};

  logic [DATA_W-1:0] func_q [FUNC_WORDS];
  logic [DATA_W-1:0] en_q   [PIN_WORDS];
  logic [DATA_W-1:0] dir_q  [PIN_WORDS];
  logic              wr_hit;

  for (genvar i = 0; i < FUNC_WORDS; i++) begin : g_func
    always_ff @(posedge clk) begin
      if (rst) func_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(FUNC_BASE + i)) func_q[i] <= wr_data;
    end
    assign func_bus[i*DATA_W +: DATA_W] = func_q[i];

    // R12: a write to function word i shows up on its bus slice
    a_r12_func_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(FUNC_BASE + i)) |=> (func_bus[i*DATA_W +: DATA_W] == $past(wr_data)));
  end

  for (genvar i = 0; i < PIN_WORDS; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        en_q[i]  <= '0;
        dir_q[i] <= '0;
      end else if (wr_en) begin
        if (wr_addr == ADDR_W'(PIN_BASE + i)) en_q[i]  <= wr_data;
        if (wr_addr == ADDR_W'(DIR_BASE + i)) dir_q[i] <= wr_data;
      end
    end
    assign en_bus[i*DATA_W +: DATA_W]  = en_q[i];
    assign dir_bus[i*DATA_W +: DATA_W] = dir_q[i];

    // R12: pin enable and direction words land in their slices
    a_r12_pin_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(PIN_BASE + i)) |=> (en_bus[i*DATA_W +: DATA_W] == $past(wr_data)));
    a_r12_dir_lands: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_addr == ADDR_W'(DIR_BASE + i)) |=> (dir_bus[i*DATA_W +: DATA_W] == $past(wr_data)));
  end

  always_comb begin
    wr_hit = 1'b0;
    for (int k = 0; k < FUNC_WORDS; k++)
      if (wr_addr == ADDR_W'(FUNC_BASE + k)) wr_hit = 1'b1;
    for (int k = 0; k < PIN_WORDS; k++)
      if (wr_addr == ADDR_W'(PIN_BASE + k) || wr_addr == ADDR_W'(DIR_BASE + k)) wr_hit = 1'b1;
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ID_ADDR)  rd_data = ID_WORD;
    if (rd_addr == VER_ADDR) rd_data = VER_WORD;
    for (int k = 0; k < FUNC_WORDS; k++)
      if (rd_addr == ADDR_W'(FUNC_BASE + k)) rd_data = func_q[k];
    for (int k = 0; k < PIN_WORDS; k++) begin
      if (rd_addr == ADDR_W'(PIN_BASE + k)) rd_data = en_q[k];
      if (rd_addr == ADDR_W'(DIR_BASE + k)) rd_data = dir_q[k];
    end
  end

  // R8, R9: a write that hits no writable word leaves every bank unchanged
  a_r9_miss_discarded: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit) |=> ($stable(func_bus) && $stable(en_bus) && $stable(dir_bus)));
endmodule

// File: rtl/strobe_reg_slave.sv
module strobe_reg_slave
  import srs_pkg::*;
#(
  parameter int         FUNC_WORDS = 2,
  parameter int         PIN_WORDS  = 3,
  parameter logic [7:0] PLAT_HI    = 8'h00,
  parameter logic [3:0] FW_BUILD   = 4'h2,
  parameter logic [3:0] FW_MINOR   = 4'h5,
  parameter logic [3:0] FW_PATCH   = 4'h1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         clr_n_i,
  input  logic                         stb_i,
  input  logic                         sdi_i,
  output logic                         sdo_o,
  output logic [FUNC_WORDS*DATA_W-1:0] func_en_o,
  output logic [PIN_WORDS*DATA_W-1:0]  pin_en_o,
  output logic [PIN_WORDS*DATA_W-1:0]  pin_dir_o
);
  logic [2:0]        raw_in;
  logic [2:0]        syn_in;
  logic [ADDR_W-1:0] look_addr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] rd_data;
  logic              wr_en;

  assign raw_in = {clr_n_i, stb_i, sdi_i};

  srs_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_in),
    .q   (syn_in)
  );

  srs_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .clr_s     (syn_in[2]),
    .stb_s     (syn_in[1]),
    .sdi_s     (syn_in[0]),
    .rd_data   (rd_data),
    .look_addr (look_addr),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .sdo       (sdo_o)
  );

  srs_regfile #(
    .FUNC_WORDS (FUNC_WORDS),
    .PIN_WORDS  (PIN_WORDS),
    .PLAT_HI    (PLAT_HI),
    .FW_BUILD   (FW_BUILD),
    .FW_MINOR   (FW_MINOR),
    .FW_PATCH   (FW_PATCH)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (look_addr),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .func_bus (func_en_o),
    .en_bus   (pin_en_o),
    .dir_bus  (pin_dir_o)
  );
endmodule

// File: tb/strobe_reg_slave_tb_top.sv
module strobe_reg_slave_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic clr_n = 1'b1;
  logic stb = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic [31:0] func_en;
  logic [47:0] pin_en;
  logic [47:0] pin_dir;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_func;
  logic [47:0] m_en;
  logic [47:0] m_dir;

  always #10 clk = ~clk;

  strobe_reg_slave dut_i (
    .clk(clk), .rst(rst), .clr_n_i(clr_n), .stb_i(stb), .sdi_i(sdi),
    .sdo_o(sdo), .func_en_o(func_en), .pin_en_o(pin_en), .pin_dir_o(pin_dir)
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic logic [15:0] model_rd(logic [6:0] a);
    int i;
    i = int'(a[3:0]);
    case (a[6:4])
      3'h1: return (a == 7'h10) ? 16'h0001 : (a == 7'h11) ? 16'h2051 : 16'h0000;
      3'h2: return (i < 2) ? m_func[i*16 +: 16] : 16'h0000;
      3'h3: return (i < 3) ? m_en[i*16 +: 16]   : 16'h0000;
      3'h4: return (i < 3) ? m_dir[i*16 +: 16]  : 16'h0000;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic model_wr(logic [6:0] a, logic [15:0] d);
    int i;
    i = int'(a[3:0]);
    if (a[6:4] == 3'h2 && i < 2) m_func[i*16 +: 16] = d;
    if (a[6:4] == 3'h3 && i < 3) m_en[i*16 +: 16]   = d;
    if (a[6:4] == 3'h4 && i < 3) m_dir[i*16 +: 16]  = d;
  endtask

  task automatic clear_pulse();
    stb = 1'b0; clr_n = 1'b0; tick(3); clr_n = 1'b1; tick(3);
  endtask

  task automatic put_bit(logic b);
    stb = 1'b0; sdi = b; tick(3); stb = 1'b1; tick(3);
  endtask

  task automatic send_hdr(logic rd, logic [6:0] a);
    logic [7:0] h;
    h = {rd, a};
    for (int i = 7; i >= 0; i--) put_bit(h[i]);
  endtask

  task automatic do_write(logic [6:0] a, logic [15:0] d);
    clear_pulse();
    send_hdr(1'b0, a);
    for (int i = 15; i >= 0; i--) put_bit(d[i]);
    stb = 1'b0; tick(4);
    model_wr(a, d);
  endtask

  task automatic do_read(logic [6:0] a, output logic [15:0] q);
    clear_pulse();
    send_hdr(1'b1, a);
    stb = 1'b0; tick(3);
    for (int i = 15; i >= 0; i--) begin
      stb = 1'b1; tick(3); stb = 1'b0; tick(3);
      q[i] = sdo;
    end
  endtask

  task automatic chk_banks(string req);
    chk({req, " func bus"}, 64'(func_en), 64'(m_func));
    chk({req, " en bus"},   64'(pin_en),  64'(m_en));
    chk({req, " dir bus"},  64'(pin_dir), 64'(m_dir));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-reqs actual=timeout expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] q;
    logic [6:0]  a;
    logic [15:0] d;
    logic [6:0]  pick [12];
    pick = '{7'h10, 7'h11, 7'h20, 7'h21, 7'h30, 7'h31, 7'h32,
             7'h40, 7'h41, 7'h42, 7'h22, 7'h7F};
    m_func = '0; m_en = '0; m_dir = '0;
    void'($urandom(32'h5EED_0C1D));

    tick(5);
    rst = 1'b0;
    tick(2);
    chk("R11 sdo after reset", 64'(sdo), 64'h0);
    chk_banks("R11 reset");

    do_read(7'h10, q); chk("R6 R2 identity read", 64'(q), 64'h0001);
    do_read(7'h11, q); chk("R7 version read", 64'(q), 64'h2051);
    chk("R7 major nibble", 64'(q[11:8]), 64'h0);

    do_write(7'h30, 16'hA5C3);
    chk("R4 R12 pin word0", 64'(pin_en[15:0]), 64'hA5C3);
    do_read(7'h30, q); chk("R5 readback 0x30", 64'(q), 64'hA5C3);
    do_write(7'h42, 16'h8001);
    chk("R12 dir word2", 64'(pin_dir[47:32]), 64'h8001);
    do_write(7'h21, 16'h7E18);
    chk("R12 func word1", 64'(func_en[31:16]), 64'h7E18);

    do_write(7'h10, 16'hFFFF);
    do_write(7'h11, 16'h0F0F);
    do_read(7'h10, q); chk("R8 identity unchanged", 64'(q), 64'h0001);
    do_read(7'h11, q); chk("R8 version unchanged", 64'(q), 64'h2051);
    chk_banks("R8 ro write");

    do_write(7'h55, 16'h1234);
    do_write(7'h22, 16'hBEEF);
    do_write(7'h33, 16'hCAFE);
    chk_banks("R9 unmapped write");
    do_read(7'h55, q); chk("R9 unmapped read 0x55", 64'(q), 64'h0);
    do_read(7'h22, q); chk("R9 unmapped read 0x22", 64'(q), 64'h0);

    // R1: clear mid-header, then a full frame must align from bit 7
    clear_pulse();
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
    do_write(7'h40, 16'h00FF);
    chk("R1 aligned after header abort", 64'(pin_dir[15:0]), 64'h00FF);
    // R1: clear mid-data must not write
    clear_pulse();
    send_hdr(1'b0, 7'h41);
    for (int i = 0; i < 10; i++) put_bit(1'b1);
    clear_pulse(); tick(4);
    chk("R1 no write after data abort", 64'(pin_dir[31:16]), 64'(m_dir[31:16]));
    do_read(7'h41, q); chk("R1 readback after abort", 64'(q), 64'(m_dir[31:16]));

    // R3: data toggled while strobe high is ignored
    clear_pulse();
    send_hdr(1'b0, 7'h31);
    d = 16'h3C96;
    for (int i = 15; i >= 0; i--) begin
      stb = 1'b0; sdi = d[i]; tick(3); stb = 1'b1; tick(3); sdi = ~d[i]; tick(2);
    end
    stb = 1'b0; tick(4);
    model_wr(7'h31, d);
    chk("R3 capture on rise only", 64'(pin_en[31:16]), 64'h3C96);

    // R10: extra strobes after a write frame
    clear_pulse();
    send_hdr(1'b0, 7'h20);
    d = 16'h1111;
    for (int i = 15; i >= 0; i--) put_bit(d[i]);
    model_wr(7'h20, d);
    for (int i = 0; i < 8; i++) put_bit(1'b1);
    stb = 1'b0; tick(4);
    chk_banks("R10 extra strobes after write");
    // R10: extra strobes after a read frame keep sdo at bit 0
    do_read(7'h30, q);
    for (int i = 0; i < 6; i++) begin
      stb = 1'b1; tick(3); stb = 1'b0; tick(3);
      chk("R10 sdo held after read", 64'(sdo), 64'(q[0]));
    end

    for (int n = 0; n < 40; n++) begin
      a = pick[$urandom_range(0, 11)];
      d = 16'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        do_write(a, d);
        chk_banks("R12 R4 random write");
      end else begin
        do_read(a, q);
        chk("R5 R9 random read", 64'(q), 64'(model_rd(a)));
      end
    end

    do_write(7'h32, 16'hFFFF);
    rst = 1'b1; tick(2); rst = 1'b0; tick(2);
    m_func = '0; m_en = '0; m_dir = '0;
    chk_banks("R11 reset after traffic");
    chk("R11 sdo after second reset", 64'(sdo), 64'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule